// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a small processor core that finishes one instruction in every clock cycle. It runs a subset of a 32-bit, fixed-length RISC instruction set: five register-register operations (add, subtract, and, or, signed set-less-than), a word load, a word store and a branch taken on equality. It holds a 32 x 32-bit register file, an ALU, an immediate sign extender, a main decoder with an ALU-operation decoder, and word-wide instruction and data memories.

Memory and register reads are combinational. Every state element (program counter, register file, data memory) updates on the same rising clock edge, so the whole fetch, decode, execute, memory and write-back path settles within one period. A load port writes either memory while reset is held, so the core can be given a program and initial data. Debug outputs show the program counter, the fetched word and the register and memory write that the current instruction commits at the next edge.

Instruction fields: opcode in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, function code in bits 5:0 and the 16-bit immediate in bits 15:0. The decoder sorts each word into one of five kinds: register-register, load, store, branch or illegal.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high the PC reads 0 and neither write strobe is asserted. After reset every register reads 0 and the first instruction fetched is the one at byte address 0.
- R2: Opcode 0x00 with function code 0x20 (add), 0x22 (sub), 0x24 (and) or 0x25 (or) writes R[rs] op R[rt] into register rd, modulo 2^32.
- R3: Opcode 0x00 with function code 0x2A writes 1 to rd when R[rs] < R[rt] as signed two's-complement values, and 0 otherwise.
- R4: Opcode 0x23 writes register rt with the data-memory word at byte address R[rs] + sign-extended imm. The word index is bits 9:2 of that address.
- R5: Opcode 0x2B writes R[rt] to the data-memory word at R[rs] + sign-extended imm. `dbg_mem_addr` shows the full byte address and `dbg_mem_data` shows the data.
- R6: Opcode 0x04 sets the next PC to PC + 4 + (sign-extended imm x 4) when R[rs] equals R[rt], and to PC + 4 otherwise. It writes no register and no memory.
- R7: Register 0 always reads 0. An instruction whose destination is register 0 raises no register write strobe.
- R8: Any other opcode, or opcode 0x00 with any other function code, writes no register and no memory, and the PC still advances by 4.
- R9: Each cycle out of reset retires exactly one instruction. Every instruction that is not a taken branch leaves the PC at PC + 4.
- R10: When `ld_en` is high, `ld_data` is written on the clock edge into word `ld_addr` of the data memory if `ld_dmem` is 1, or of the instruction memory if it is 0. `dbg_insn` shows the instruction-memory word at PC bits 9:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write enable |
| ld_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| ld_addr | input | 8 | Load word index |
| ld_data | input | 32 | Load word |
| dbg_pc | output | 32 | Current program counter |
| dbg_insn | output | 32 | Instruction word at the PC |
| dbg_rf_we | output | 1 | Register write committed at the next edge |
| dbg_rf_addr | output | 5 | Destination register |
| dbg_rf_data | output | 32 | Write-back value |
| dbg_mem_we | output | 1 | Data-memory write committed at the next edge |
| dbg_mem_addr | output | 32 | Data-memory byte address (ALU result) |
| dbg_mem_data | output | 32 | Store data (R[rt]) |

## Verification
Every write is visible at the debug outputs in the same cycle as the instruction that makes it. A wrong register or memory value therefore shows up in the write-back data of the first later instruction that reads it, usually within a few cycles. A wrong next-PC shows up one cycle later as a mismatch of `dbg_pc` and `dbg_insn`, and every later fetch stays off track. Decoder mistakes show up at once as a wrong or missing strobe.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        K_RTYPE,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_ILLEGAL
    } ikind_e;

    typedef struct packed {
        logic    rf_we;     // writes a register
        logic    dst_rt;    // destination from rt instead of rd
        logic    src_imm;   // ALU B from immediate
        logic    mem_we;    // writes data memory
        logic    from_mem;  // write-back from data memory
        logic    branch;    // conditional branch on equality
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/onecyc_decode.sv
module onecyc_decode
    import onecyc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ikind_e     kind,
    output ctrl_t      ctrl
);

    always_comb begin
        kind          = K_ILLEGAL;
        ctrl.rf_we    = 1'b0;
        ctrl.dst_rt   = 1'b0;
        ctrl.src_imm  = 1'b0;
        ctrl.mem_we   = 1'b0;
        ctrl.from_mem = 1'b0;
        ctrl.branch   = 1'b0;
        ctrl.alu_op   = ALU_ADD;

        unique case (opcode)
            OP_RTYPE: begin
                // ALU-operation decode from the function field
                unique case (funct)
                    FN_ADD:  begin kind = K_RTYPE; ctrl.alu_op = ALU_ADD; end
                    FN_SUB:  begin kind = K_RTYPE; ctrl.alu_op = ALU_SUB; end
                    FN_AND:  begin kind = K_RTYPE; ctrl.alu_op = ALU_AND; end
                    FN_OR:   begin kind = K_RTYPE; ctrl.alu_op = ALU_OR;  end
                    FN_SLT:  begin kind = K_RTYPE; ctrl.alu_op = ALU_SLT; end
                    default: kind = K_ILLEGAL;
                endcase
                ctrl.rf_we = (kind == K_RTYPE);
            end
            OP_LOAD: begin
                kind          = K_LOAD;
                ctrl.rf_we    = 1'b1;
                ctrl.dst_rt   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.from_mem = 1'b1;
                ctrl.alu_op   = ALU_ADD;
            end
            OP_STORE: begin
                kind         = K_STORE;
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OP_BEQ: begin
                kind        = K_BRANCH;
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: kind = K_ILLEGAL;
        endcase

        // R8
        if (kind == K_ILLEGAL) begin
            illegal_quiet_chk: assert (!ctrl.rf_we && !ctrl.mem_we && !ctrl.branch);
        end
    end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
    import onecyc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (y == '0);

        // R3
        if (op == ALU_SLT) begin
            slt_range_chk: assert (y[W-1:1] == '0);
        end
    end

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

    // R2
    rf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
    import onecyc_pkg::*;
#(
    parameter int MEM_AW = 8,
    localparam int W = 32,
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [W-1:0]      ld_data,
    output logic [W-1:0]      dbg_pc,
    output logic [W-1:0]      dbg_insn,
    output logic              dbg_rf_we,
    output logic [4:0]        dbg_rf_addr,
    output logic [W-1:0]      dbg_rf_data,
    output logic              dbg_mem_we,
    output logic [W-1:0]      dbg_mem_addr,
    output logic [W-1:0]      dbg_mem_data
);

    logic [W-1:0] imem [DEPTH];
    logic [W-1:0] dmem [DEPTH];

    logic [W-1:0] pc, pc_seq, pc_br, pc_next;
    logic [W-1:0] insn;
    logic [4:0]   f_rs, f_rt, f_rd, dst;
    logic [15:0]  f_imm;
    logic [W-1:0] imm_ext, ra, rb, alu_b, alu_y, mem_rd, wb;
    logic         alu_zero, rf_we, mem_we, taken;
    logic [MEM_AW-1:0] mem_idx;
    ikind_e       kind;
    ctrl_t        ctrl;

    // fetch
    assign insn  = imem[pc[MEM_AW+1:2]];
    assign f_rs  = insn[25:21];
    assign f_rt  = insn[20:16];
    assign f_rd  = insn[15:11];
    assign f_imm = insn[15:0];
    assign imm_ext = {{(W-16){f_imm[15]}}, f_imm};

    onecyc_decode u_dec (
        .opcode (insn[31:26]),
        .funct  (insn[5:0]),
        .kind   (kind),
        .ctrl   (ctrl)
    );

    assign dst   = ctrl.dst_rt ? f_rt : f_rd;
    assign rf_we = ctrl.rf_we && !rst && (dst != 5'd0);

    onecyc_regfile #(.W(W), .N(32)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (dst),
        .wdata   (wb),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (ra),
        .rdata_b (rb)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rb;

    onecyc_alu #(.W(W)) u_alu (
        .a    (ra),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: combinational read, edge write
    assign mem_idx = alu_y[MEM_AW+1:2];
    assign mem_rd  = dmem[mem_idx];
    assign mem_we  = ctrl.mem_we && !rst;
    assign wb      = ctrl.from_mem ? mem_rd : alu_y;

    always_ff @(posedge clk) begin
        if (ld_en && ld_dmem) dmem[ld_addr] <= ld_data;
        else if (mem_we)      dmem[mem_idx] <= rb;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_dmem) imem[ld_addr] <= ld_data;
    end

    // next PC
    assign taken   = ctrl.branch && alu_zero;
    assign pc_seq  = pc + 32'd4;
    assign pc_br   = pc_seq + (imm_ext << 2);
    assign pc_next = taken ? pc_br : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    assign dbg_pc       = pc;
    assign dbg_insn     = insn;
    assign dbg_rf_we    = rf_we;
    assign dbg_rf_addr  = dst;
    assign dbg_rf_data  = wb;
    assign dbg_mem_we   = mem_we;
    assign dbg_mem_addr = alu_y;
    assign dbg_mem_data = rb;

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == '0));

    // R6
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> (pc == $past(pc) + 32'd4 + ($past(imm_ext) << 2)));

    // R9
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        !taken |=> (pc == $past(pc) + 32'd4));

    // R5
    store_kind_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_mem_we |-> (kind == K_STORE));

endmodule

// File: tb/onecyc_core_bench.sv
module onecyc_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc, dbg_insn, dbg_rf_data, dbg_mem_addr, dbg_mem_data;
    logic        dbg_rf_we, dbg_mem_we;
    logic [4:0]  dbg_rf_addr;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] prog  [DEPTH];
    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_rf  [32];
    logic [31:0] m_pc;
    int          plen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    onecyc_core u_onecyc_core (
        .clk          (clk),
        .rst          (rst),
        .ld_en        (ld_en),
        .ld_dmem      (ld_dmem),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .dbg_pc       (dbg_pc),
        .dbg_insn     (dbg_insn),
        .dbg_rf_we    (dbg_rf_we),
        .dbg_rf_addr  (dbg_rf_addr),
        .dbg_rf_data  (dbg_rf_data),
        .dbg_mem_we   (dbg_mem_we),
        .dbg_mem_addr (dbg_mem_addr),
        .dbg_mem_data (dbg_mem_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // one cycle of the reference model: compare, then advance
    task automatic step(input bit first);
        logic [31:0] w, a, b, y, sx, nxt;
        logic [5:0]  op, fn;
        logic        e_rf, e_mem;
        logic [4:0]  e_dst;
        logic [31:0] e_wb;
        string       tag;
        w   = prog[m_pc[9:2]];
        op  = w[31:26];
        fn  = w[5:0];
        a   = m_rf[w[25:21]];
        b   = m_rf[w[20:16]];
        sx  = {{16{w[15]}}, w[15:0]};
        nxt = m_pc + 32'd4;
        e_rf = 1'b0; e_mem = 1'b0; e_dst = w[15:11]; e_wb = '0; y = '0;
        tag = "R8";
        if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)) begin
            tag = (fn == 6'h2A) ? "R3" : "R2";
            case (fn)
                6'h20: y = a + b;
                6'h22: y = a - b;
                6'h24: y = a & b;
                6'h25: y = a | b;
                default: y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            endcase
            e_rf = 1'b1; e_wb = y;
        end else if (op == 6'h23) begin
            tag = "R4"; y = a + sx; e_dst = w[20:16];
            e_rf = 1'b1; e_wb = m_mem[y[9:2]];
        end else if (op == 6'h2B) begin
            tag = "R5"; y = a + sx; e_mem = 1'b1;
        end else if (op == 6'h04) begin
            tag = "R6";
            if (a == b) nxt = m_pc + 32'd4 + (sx << 2);
        end
        if (e_rf && e_dst == 5'd0) begin
            e_rf = 1'b0; tag = "R7";
        end
        if (first) tag = "R1";

        chk(dbg_pc == m_pc, "R9", "pc", dbg_pc, m_pc);
        chk(dbg_insn == w, "R10", "fetched word", dbg_insn, w);
        chk(dbg_rf_we == e_rf, tag, "rf write strobe", {31'd0, dbg_rf_we}, {31'd0, e_rf});
        if (e_rf) begin
            chk(dbg_rf_addr == e_dst, tag, "rf dest", {27'd0, dbg_rf_addr}, {27'd0, e_dst});
            chk(dbg_rf_data == e_wb, tag, "rf data", dbg_rf_data, e_wb);
            m_rf[e_dst] = e_wb;
        end
        chk(dbg_mem_we == e_mem, tag, "mem write strobe", {31'd0, dbg_mem_we}, {31'd0, e_mem});
        if (e_mem) begin
            chk(dbg_mem_addr == y, tag, "mem addr", dbg_mem_addr, y);
            chk(dbg_mem_data == b, tag, "mem data", dbg_mem_data, b);
            m_mem[y[9:2]] = b;
        end
        m_pc = nxt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] fns [5];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;

        // data image
        for (int i = 0; i < DEPTH; i++) m_mem[i] = i * 32'h01010101 + 32'h5A;
        m_mem[0] = 32'h0000_0000;
        m_mem[1] = 32'h0000_0001;
        m_mem[2] = 32'hFFFF_FFFF;
        m_mem[3] = 32'h7FFF_FFFF;
        m_mem[4] = 32'h8000_0000;
        m_mem[5] = 32'd16;
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < DEPTH; i++) prog[i] = 32'hFC00_0000;

        // R1: registers cleared by reset, read back through an add
        emit(enc_r(1, 2, 7, 6'h20));
        // R4: load operands
        for (int i = 1; i <= 6; i++) emit(enc_i(6'h23, 0, i, (i - 1) * 4));
        // R2/R3: sweep every operand pair and every function
        for (int i = 1; i <= 5; i++)
            for (int j = 1; j <= 5; j++)
                for (int f = 0; f < 5; f++)
                    emit(enc_r(i, j, 7 + ((i + j + f) % 6), fns[f]));
        // R7: write to register 0, then store it
        emit(enc_r(2, 3, 0, 6'h20));
        emit(enc_i(6'h2B, 0, 0, 40));
        // R4/R5: negative offset load, store, load back
        emit(enc_i(6'h23, 6, 13, -8));
        emit(enc_i(6'h2B, 6, 3, 4));
        emit(enc_i(6'h23, 0, 14, 20));
        emit(enc_i(6'h2B, 6, 5, -12));
        emit(enc_i(6'h23, 6, 15, -12));
        // R8: unknown opcode and unknown function code
        emit({6'h3F, 5'd1, 5'd9, 16'h1234});
        emit(enc_r(2, 3, 9, 6'h00));
        emit(enc_r(2, 3, 9, 6'h26));
        // R6: taken, not taken, zero offset, skip two, backward not taken
        emit(enc_i(6'h04, 2, 2, 1));
        emit(enc_r(2, 2, 16, 6'h20));
        emit(enc_i(6'h04, 2, 3, 5));
        emit(enc_i(6'h04, 1, 0, 0));
        emit(enc_i(6'h04, 4, 4, 2));
        emit(enc_r(3, 3, 17, 6'h20));
        emit(enc_i(6'h2B, 0, 3, 60));
        emit(enc_i(6'h04, 2, 3, -3));
        emit(enc_i(6'h04, 5, 5, -1));
        emit(enc_r(3, 4, 18, 6'h22));
        emit(enc_i(6'h2B, 0, 18, 64));

        // load both memories while reset is held (R10)
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = i[7:0]; ld_data = prog[i];
        end
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_dmem = 1'b1; ld_addr = i[7:0]; ld_data = m_mem[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        // R1: state during reset
        chk(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
        chk(!dbg_rf_we, "R1", "rf strobe in reset", {31'd0, dbg_rf_we}, 32'd0);
        chk(!dbg_mem_we, "R1", "mem strobe in reset", {31'd0, dbg_mem_we}, 32'd0);
        @(negedge clk);
        #1;
        chk(dbg_pc == 32'd0, "R1", "pc held in reset", dbg_pc, 32'd0);

        m_pc = 32'd0;
        rst = 1'b0;
        #1;
        for (int c = 0; c < plen + 4; c++) begin
            step(c == 0);
            @(negedge clk);
            #1;
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule